// File: doc/BRIEF.md
# Parallel EPROM Read-Cycle Controller

This block sits on the host side of a bank of parallel, word-wide EPROM devices. It takes one read request at a time from a valid/ready request channel. The upper request address bits pick a device and the lower bits form the word address. The block decodes the device number into a set of active-low chip selects, with one line per device. It drives a single active-low output-enable line that all devices share. Every delay it needs is counted in whole clock cycles. The cycle counts come from the clock period and the access-time grade, which are both parameters, and each count is the ceiling of time divided by period.

A read first drives the word address and the chip select. The block then waits the difference between the address access time and the output-enable access time, and after that it pulls output enable low. It samples the data bus once output enable has been low for the output-enable access count. It raises output enable at that same edge and starts a float timer. When a later read goes to a different device, output enable stays high until the float timer expires. This keeps two devices from ever driving the bus at the same time. The last addressed device keeps its chip select low between reads, so a read to the same device does not wait for the float timer.

The response leaves on a valid/ready channel. `rsp_valid` stays high and `rsp_data` stays frozen until the consumer asserts `rsp_ready`. No new request is taken until then, so a stalled consumer holds back the request side as well.

Top module: `eprc_ctrl`

## Requirements
- R1: After reset, every `mem_ce_n` bit is 1, `mem_oe_n` is 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: The device number is the top `$clog2(DEV_CNT)` bits of `req_addr`, and device k owns `mem_ce_n[k]`. The low `WORD_AW` bits appear on `mem_addr`. At most one `mem_ce_n` bit is ever 0.
- R3: After a read completes, the chip select of the device just read stays 0 until a request for another device is accepted.
- R4: `mem_oe_n` is 0 only while exactly one chip select is 0.
- R5: While `mem_oe_n` is 0, neither `mem_addr` nor `mem_ce_n` changes.
- R6: `rsp_data` equals the word on `mem_data` at an edge where the address and chip select have been stable for at least ACC_CYC = ceil(T_ACC/T_CLK) cycles and output enable has been low for at least OE_CYC = ceil(T_OE/T_CLK) cycles.
- R7: When a read targets a device other than the one that drove last, `mem_oe_n` falls at least DF_CYC = ceil(T_DF/T_CLK) cycles after its previous rise, and at most DF_CYC+1 cycles after it when the request is already waiting.
- R8: When no float wait is pending, and always when a read goes to the same device as the previous one, `mem_oe_n` falls ACC_CYC−OE_CYC+1 cycles after the request is accepted.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1, `rsp_data` holds its value and `req_ready` is 0.
- R10: When no float wait is pending, `rsp_valid` rises ACC_CYC+1 cycles after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle, request taken this edge if valid |
| req_addr | input | WORD_AW+$clog2(DEV_CNT) | Device number (upper bits) and word address |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | DW | Sampled word |
| mem_addr | output | WORD_AW | Word address to the device bank |
| mem_ce_n | output | DEV_CNT | Active-low chip select, one per device |
| mem_oe_n | output | 1 | Active-low output enable, shared |
| mem_data | input | DW | Data bus from the device bank |

## Verification
The bench models each device with cycle-accurate access and float windows. If the controller samples too early, the model returns a garbage word and the data check fails. If the controller drops output enable before the previous device has floated, the model counts bus contention. If it skips the float gap on a device switch, the measured rise-to-fall gap comes out short. The same-device back-to-back case checks for the opposite fault: a design that waits for the float timer anyway gives a longer output-enable latency than R8 allows. Consumer back-pressure is held for several cycles to show that a design letting data or readiness slip drops or corrupts a word.

// File: rtl/eprc_pkg.sv
package eprc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RESP
  } eprc_state_e;

  // whole clock cycles needed to cover a delay
  function automatic int cyc_ceil(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/eprc_decode.sv
module eprc_decode #(
  parameter int DEV_CNT = 4,
  parameter int DEV_W   = 2
) (
  input  logic               en,
  input  logic [DEV_W-1:0]   sel,
  output logic [DEV_CNT-1:0] ce_n
);
  for (genvar i = 0; i < DEV_CNT; i++) begin : g_dev
    assign ce_n[i] = ~(en && (sel == DEV_W'(i)));
  end
endmodule

// File: rtl/eprc_down_timer.sv
module eprc_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (count != '0)    count <= count - 1'b1;
  end
endmodule

// File: rtl/eprc_ctrl.sv
module eprc_ctrl
  import eprc_pkg::*;
#(
  parameter int DEV_CNT  = 4,
  parameter int WORD_AW  = 18,
  parameter int DW       = 16,
  parameter int CLK_PS   = 10000,
  parameter int T_ACC_PS = 45000,
  parameter int T_OE_PS  = 25000,
  parameter int T_DF_PS  = 30000
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic [WORD_AW+((DEV_CNT>1)?$clog2(DEV_CNT):1)-1:0] req_addr,
  output logic                                rsp_valid,
  input  logic                                rsp_ready,
  output logic [DW-1:0]                       rsp_data,
  output logic [WORD_AW-1:0]                  mem_addr,
  output logic [DEV_CNT-1:0]                  mem_ce_n,
  output logic                                mem_oe_n,
  input  logic [DW-1:0]                       mem_data
);
  localparam int DEV_W   = (DEV_CNT > 1) ? $clog2(DEV_CNT) : 1;
  localparam int ADDR_W  = WORD_AW + DEV_W;
  localparam int ACC_CYC = cyc_ceil(T_ACC_PS, CLK_PS);
  localparam int OE_RAW  = cyc_ceil(T_OE_PS, CLK_PS);
  localparam int OE_CYC  = (OE_RAW < 1) ? 1 : OE_RAW;
  localparam int DF_CYC  = cyc_ceil(T_DF_PS, CLK_PS);
  localparam int LEAD    = (ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0;
  localparam int CNT_MAX = (ACC_CYC > DF_CYC) ? ACC_CYC : DF_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 2);

  eprc_state_e        state;
  logic [WORD_AW-1:0] addr_q;
  logic [DEV_W-1:0]   dev_q;
  logic               sel_v;
  logic               same_q;
  logic               oe_n_q;
  logic [DW-1:0]      data_q;

  logic [CNT_W-1:0]   ph_cnt, df_cnt, ph_val;
  logic               ph_load, go_oe, take_req, sample;
  logic [DEV_W-1:0]   dev_new;

  assign dev_new  = req_addr[ADDR_W-1 -: DEV_W];
  assign take_req = (state == ST_IDLE) && req_valid;
  assign go_oe    = (state == ST_SETUP) && (ph_cnt == '0) && (same_q || df_cnt == '0);
  assign sample   = (state == ST_STROBE) && (ph_cnt == CNT_W'(1));
  assign ph_load  = take_req || go_oe;
  assign ph_val   = take_req ? CNT_W'(LEAD) : CNT_W'(OE_CYC);

  // phase timer: lead-in before strobe, then strobe length
  eprc_down_timer #(.W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .count(ph_cnt)
  );

  // float timer: started when output enable is released
  eprc_down_timer #(.W(CNT_W)) u_float (
    .clk(clk), .rst_n(rst_n), .load(sample), .load_val(CNT_W'(DF_CYC)), .count(df_cnt)
  );

  eprc_decode #(.DEV_CNT(DEV_CNT), .DEV_W(DEV_W)) u_decode (
    .en(sel_v), .sel(dev_q), .ce_n(mem_ce_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      dev_q  <= '0;
      sel_v  <= 1'b0;
      same_q <= 1'b0;
      oe_n_q <= 1'b1;
      data_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          same_q <= sel_v && (dev_q == dev_new);
          dev_q  <= dev_new;
          sel_v  <= 1'b1;
          addr_q <= req_addr[WORD_AW-1:0];
          state  <= ST_SETUP;
        end
        ST_SETUP: if (go_oe) begin
          oe_n_q <= 1'b0;
          state  <= ST_STROBE;
        end
        ST_STROBE: if (sample) begin
          data_q <= mem_data;
          oe_n_q <= 1'b1;
          state  <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_data  = data_q;
  assign mem_addr  = addr_q;
  assign mem_oe_n  = oe_n_q;

endmodule

// File: rtl/eprc_chk.sv
module eprc_chk #(
  parameter int DEV_CNT = 4,
  parameter int WORD_AW = 18,
  parameter int DW      = 16,
  parameter int DF_CYC  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [DEV_CNT-1:0] mem_ce_n,
  input logic               mem_oe_n,
  input logic [WORD_AW-1:0] mem_addr,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [DW-1:0]      rsp_data
);
  logic               oe_d;
  logic [15:0]        gap;
  logic [DEV_CNT-1:0] ce_at_rise;

  // cycles since output enable was last released, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_d       <= 1'b1;
      gap        <= 16'(DF_CYC);
      ce_at_rise <= '1;
    end else begin
      oe_d <= mem_oe_n;
      if (mem_oe_n && !oe_d) begin
        gap        <= 16'd1;
        ce_at_rise <= mem_ce_n;
      end else if (gap < 16'(DF_CYC)) begin
        gap <= gap + 16'd1;
      end
    end
  end

  p_ce_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_ce_n) <= 1);

  p_oe_single_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> $countones(~mem_ce_n) == 1);

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && !$past(mem_oe_n)) |-> ($stable(mem_addr) && $stable(mem_ce_n)));

  p_float_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && oe_d && mem_ce_n != ce_at_rise) |-> gap >= 16'(DF_CYC));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && req_ready));

endmodule

bind eprc_ctrl eprc_chk #(
  .DEV_CNT(DEV_CNT), .WORD_AW(WORD_AW), .DW(DW), .DF_CYC(DF_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_addr(mem_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data)
);

// File: tb/eprc_ctrl_tb.sv
module eprc_ctrl_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PERIOD_NS = 10;
  localparam int TB_ACC  = 5;   // ceil(45/10)
  localparam int TB_OE   = 3;   // ceil(25/10)
  localparam int TB_DF   = 8;   // ceil(80/10)
  localparam int NDEV    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_data;
  logic [17:0] mem_addr;
  logic [3:0]  mem_ce_n;
  logic        mem_oe_n;
  logic [15:0] mem_data = 16'hFFFF;

  int tests = 0, fails = 0;
  int cyc = 0, acc_cyc = 0, oe_fall_cyc = 0, oe_rise_cyc = 0, rsp_cyc = 0, oe_gap = 0;
  int acc_age = 0, oe_age = 0, contention = 0, addr_bad = 0;
  int fl [NDEV];
  logic        prev_oe = 1'b1, prev_rv = 1'b0;
  logic [17:0] prev_addr = '0;
  logic [3:0]  prev_ce = 4'hF;
  bit          done = 1'b0;

  always #(CLK_PERIOD_NS/2) clk = ~clk;

  eprc_ctrl #(.T_DF_PS(80000)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_data(mem_data)
  );

  function automatic logic [15:0] word_of(input int dev, input logic [17:0] a);
    logic [1:0] d2;
    d2 = 2'(dev);
    return {d2, a[13:0]} ^ 16'h3C5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // device bank model, updated away from the active edge
  initial for (int d = 0; d < NDEV; d++) fl[d] = 0;
  always @(negedge clk) begin
    int drivers, act_dev;
    if (!mem_oe_n && prev_oe) begin oe_fall_cyc = cyc; oe_gap = cyc - oe_rise_cyc; end
    if (mem_oe_n && !prev_oe) oe_rise_cyc = cyc;
    if (rsp_valid && !prev_rv) rsp_cyc = cyc;
    if (!mem_oe_n && !prev_oe && (mem_addr != prev_addr || mem_ce_n != prev_ce)) addr_bad++;
    if (mem_ce_n != prev_ce || mem_addr != prev_addr) acc_age = 1;
    else if (acc_age < 1000) acc_age++;
    if (mem_oe_n) oe_age = 0; else oe_age++;
    drivers = 0; act_dev = -1;
    for (int d = 0; d < NDEV; d++) begin
      if (!mem_ce_n[d] && !mem_oe_n) begin fl[d] = TB_DF; act_dev = d; end
      else if (fl[d] > 0) fl[d]--;
      if (fl[d] != 0) drivers++;
    end
    if (drivers > 1) contention++;
    if (drivers == 0) mem_data = 16'hFFFF;
    else if (drivers == 1 && act_dev >= 0 && acc_age >= TB_ACC && oe_age >= TB_OE)
      mem_data = word_of(act_dev, mem_addr);
    else mem_data = 16'hDEAD;
    prev_oe = mem_oe_n; prev_rv = rsp_valid; prev_addr = mem_addr; prev_ce = mem_ce_n;
  end

  // issue one read; called and returning at a negedge
  task automatic read_word(input int dev, input logic [17:0] a, input int stall,
                           output logic [15:0] d);
    req_addr  = {2'(dev), a};
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    acc_cyc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == d && !req_ready, "R9 hold under stall",
          {rsp_valid, req_ready}, 2'b10);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(mem_ce_n == 4'hF, "R1 ce", mem_ce_n, 4'hF);
    chk(mem_oe_n == 1'b1 && rsp_valid == 1'b0 && req_ready == 1'b1, "R1 controls",
        {mem_oe_n, rsp_valid, req_ready}, 3'b101);
  endtask

  task automatic t_single();
    logic [15:0] d;
    read_word(1, 18'h2_1234, 0, d);
    chk(d == word_of(1, 18'h2_1234), "R6 data dev1", d, word_of(1, 18'h2_1234));
    chk(oe_fall_cyc - acc_cyc == TB_ACC - TB_OE + 1, "R8 oe latency", oe_fall_cyc - acc_cyc,
        TB_ACC - TB_OE + 1);
    chk(rsp_cyc - acc_cyc == TB_ACC + 1, "R10 rsp latency", rsp_cyc - acc_cyc, TB_ACC + 1);
    chk(mem_ce_n == 4'b1101 && mem_addr == 18'h2_1234, "R2 decode/addr", mem_ce_n, 4'b1101);
  endtask

  task automatic t_same_dev();
    logic [15:0] d;
    chk(mem_ce_n == 4'b1101, "R3 ce kept between reads", mem_ce_n, 4'b1101);
    read_word(1, 18'h0_0007, 0, d);
    chk(d == word_of(1, 18'h0_0007), "R6 data same dev", d, word_of(1, 18'h0_0007));
    chk(oe_fall_cyc - acc_cyc == TB_ACC - TB_OE + 1, "R8 no float wait same dev",
        oe_fall_cyc - acc_cyc, TB_ACC - TB_OE + 1);
  endtask

  task automatic t_switch();
    logic [15:0] d;
    read_word(2, 18'h1_5555, 0, d);
    chk(d == word_of(2, 18'h1_5555), "R6 data after switch", d, word_of(2, 18'h1_5555));
    chk(oe_gap >= TB_DF && oe_gap <= TB_DF + 1, "R7 float gap", oe_gap, TB_DF);
    chk(mem_ce_n == 4'b1011, "R2 ce dev2", mem_ce_n, 4'b1011);
  endtask

  task automatic t_stall();
    logic [15:0] d;
    read_word(2, 18'h3_AAAA, 4, d);
    chk(d == word_of(2, 18'h3_AAAA), "R9 data after stall", d, word_of(2, 18'h3_AAAA));
    chk(!rsp_valid && req_ready, "R9 released", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic t_sweep();
    logic [15:0] d;
    for (int k = 0; k < NDEV; k++) begin
      logic [17:0] a;
      a = (k[0]) ? 18'h3_FFFF : 18'h0_0000;
      read_word(k, a, 0, d);
      chk(d == word_of(k, a), "R2 R6 sweep data", d, word_of(k, a));
      chk(mem_ce_n == ~(4'b1 << k), "R2 sweep ce", mem_ce_n, ~(4'b1 << k));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_same_dev();
    t_switch();
    t_stall();
    t_sweep();
    repeat (12) @(negedge clk);
    chk(contention == 0, "R4 R7 bus contention", contention, 0);
    chk(addr_bad == 0, "R5 addr stable during strobe", addr_bad, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD_NS * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule